// File: doc/BRIEF.md
# Randomised Fair Shared-Port Arbiter

This block decides which of several cores may use a single shared memory port in the current cycle. Any cycle in which at least one core raises its request line produces exactly one grant, so the port never sits idle while work is waiting. The winner is drawn at random from the cores that are currently eligible. A pseudo-random generator supplies the draw, and its value is reduced modulo the number of eligible cores so that every one of them can be picked.

Randomness alone could starve a core forever. A served mask prevents this. Every winner is recorded in the mask. A recorded core cannot win again while any requesting core has not yet been served in the current round. Once every requesting core has won, the round restarts and all requesters are eligible again. The grant is combinational on the request lines, is one-hot, and the memory port consumes it in the same cycle.

Top module: `rand_fair_arb`

## Requirements
- R1: While `rstN` is low, `gnt` is all zeros whatever `req` holds. The first cycle after reset starts with an empty served mask.
- R2: In a cycle where `req` is all zeros, `gnt` is all zeros.
- R3: In a cycle where `req` has at least one bit set, exactly one bit of `gnt` is high. Bit i of `gnt` grants core i, the same core that drives bit i of `req`.
- R4: A `gnt` bit is only ever high when the matching `req` bit is high in the same cycle.
- R5: A core that has won in the current round is not granted again while some requesting core has not yet won in that round.
- R6: When every currently requesting core has already won in the round, the round restarts and all requesters are eligible. A lone requester is therefore granted on every cycle.
- R7: The served mask is kept through cycles with no request. After an idle gap, a round that was in progress continues, and its earlier winner stays excluded.
- R8: The draw comes from a 16-bit maximal-length LFSR that is loaded with a nonzero seed at reset, never holds zero, and steps every cycle. The LFSR value modulo the eligible count N selects the k-th eligible core, counted from bit 0 upward. The first winner of a round therefore varies from round to round.
- R9: With all 16 cores requesting continuously, every run of 16 consecutive grants aligned to a round start covers each core exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 16 | Request line per core, bit i for core i |
| gnt | output | 16 | One-hot grant, bit i for core i, valid in the same cycle as `req` |

## Verification
The bench builds the arbiter with its defaults: 16 requesters, a 16-bit generator and seed 16'hACE1. With these values a run of full contention spans 16 grants, so whole rounds and the wrap back to a fresh round are reached in a few dozen cycles. The bench keeps its own served mask, built from the observed grants according to the round rules. From that mask it derives the eligible set on every cycle, which lets it check fairness without predicting the random draw. Directed sequences cover idle gaps in the middle of a round, a round restart with two requesters, and variation in the first winner across rounds.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic grantEn;   // a grant must be issued this cycle
    logic newRound;  // no unserved requester remains: treat mask as empty
  } arbStrobe_t;
endpackage

// File: rtl/rfa_lfsr.sv
module rfa_lfsr #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter logic [15:0] TAPS  = 16'hD008   // x^16+x^15+x^13+x^4+1
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [WIDTH-1:0] rnd
);
  logic [WIDTH-1:0] stateQ;
  logic             feedback;

  assign feedback = ^(stateQ & TAPS[WIDTH-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEED[WIDTH-1:0];
    else       stateQ <= {stateQ[WIDTH-2:0], feedback};
  end

  assign rnd = stateQ;

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN) stateQ != '0);
  // R8
  lfsr_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ[WIDTH-1:1] == $past(stateQ[WIDTH-2:0])) || !$past(rstN));
endmodule

// File: rtl/rfa_ctrl.sv
module rfa_ctrl
  import rfa_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] req,
  input  logic               unservedAny,
  output arbStrobe_t         strobe
);
  logic anyReq;

  assign anyReq = |req;

  always_comb begin
    strobe.grantEn  = rstN && anyReq;
    strobe.newRound = anyReq && !unservedAny;
  end
endmodule

// File: rtl/rfa_dp.sv
module rfa_dp
  import rfa_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int RND_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] req,
  input  logic [RND_W-1:0]   rnd,
  input  arbStrobe_t         strobe,
  output logic               unservedAny,
  output logic [NUM_REQ-1:0] gnt
);
  logic [NUM_REQ-1:0] servedQ;
  logic [NUM_REQ-1:0] eligRaw;
  logic [NUM_REQ-1:0] elig;
  logic [NUM_REQ-1:0] pick;
  logic [RND_W-1:0]   eligCnt;
  logic [RND_W-1:0]   drawIdx;

  assign eligRaw     = req & ~servedQ;
  assign unservedAny = |eligRaw;
  assign elig        = strobe.newRound ? req : eligRaw;

  // population count of the eligible set
  always_comb begin
    eligCnt = '0;
    for (int i = 0; i < NUM_REQ; i++) eligCnt = eligCnt + RND_W'(elig[i]);
  end

  // random draw reduced to 0..N-1
  assign drawIdx = (eligCnt == '0) ? '0 : (rnd % eligCnt);

  // select the drawIdx-th eligible bit, counting from bit 0
  always_comb begin
    logic [RND_W-1:0] seen;
    seen = '0;
    pick = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i]) begin
        if (seen == drawIdx) pick[i] = 1'b1;
        seen = seen + 1'b1;
      end
    end
  end

  assign gnt = strobe.grantEn ? pick : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               servedQ <= '0;
    else if (strobe.grantEn) servedQ <= (strobe.newRound ? '0 : servedQ) | gnt;
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt) && ((|req) == (|gnt)));
  // R4
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gnt & ~req) == '0);
  // R5
  no_repeat_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(req & ~servedQ)) |-> ((gnt & servedQ) == '0));
  // R7
  mask_records_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|gnt) |=> ((servedQ & $past(gnt)) != '0));
  // R7
  mask_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req == '0) |=> $stable(servedQ));
endmodule

// File: rtl/rand_fair_arb.sv
module rand_fair_arb
  import rfa_pkg::*;
#(
  parameter int          NUM_REQ = 16,
  parameter int          RND_W   = 16,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt
);
  arbStrobe_t       strobe;
  logic             unservedAny;
  logic [RND_W-1:0] rnd;

  rfa_lfsr #(.WIDTH(RND_W), .SEED(SEED)) uRnd (
    .clk(clk), .rstN(rstN), .rnd(rnd));

  rfa_ctrl #(.NUM_REQ(NUM_REQ)) uCtrl (
    .rstN(rstN), .req(req), .unservedAny(unservedAny), .strobe(strobe));

  rfa_dp #(.NUM_REQ(NUM_REQ), .RND_W(RND_W)) uDp (
    .clk(clk), .rstN(rstN), .req(req), .rnd(rnd), .strobe(strobe),
    .unservedAny(unservedAny), .gnt(gnt));
endmodule

// File: tb/tb_rand_fair_arb.sv
module tb_rand_fair_arb;
  localparam int N = 16;
  localparam int NV = 11;
  // {request pattern, cycles held}
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 8'd3}, {16'h0001, 8'd4}, {16'h8001, 8'd6}, {16'h00F0, 8'd5},
    {16'h1248, 8'd7}, {16'h0000, 8'd2}, {16'h0007, 8'd5}, {16'hFFFF, 8'd20},
    {16'hAAAA, 8'd9}, {16'h5555, 8'd9}, {16'h0003, 8'd4}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic [N-1:0] model = '0;
  int vecs = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rand_fair_arb dut (.clk(clk), .rstN(rstN), .req(req), .gnt(gnt));

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic fail(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    bad++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  // drive at negedge, check 1 ns later, update model at the next rising edge
  task automatic step(input logic [N-1:0] r);
    logic [N-1:0] raw, elig;
    @(negedge clk);
    req = r;
    #1;
    vecs++;
    raw  = r & ~model;
    elig = (raw != '0) ? raw : r;
    if (r == '0) begin
      if (gnt != '0) fail("R2 idle grant", gnt, '0);
    end else if (ones(gnt) != 1) begin
      fail("R3 one-hot grant", gnt, elig);
    end else if ((gnt & ~r) != '0) begin
      fail("R4 grant outside req", gnt, r);
    end else if ((gnt & ~elig) != '0) begin
      fail("R5/R6 grant outside eligible set", gnt, elig);
    end
    @(posedge clk);
    if (r != '0) model = ((raw == '0) ? '0 : model) | gnt;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    req = '1;
    #1;
    vecs++;
    if (gnt != '0) fail("R1 grant during reset", gnt, '0);
    @(negedge clk);
    rstN = 1'b1;
    req = '0;
    model = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] seen, w, w2, first, firstSeen;
    doReset();

    // R9: full contention after reset, 16 grants cover every core once
    seen = '0;
    for (int c = 0; c < 16; c++) begin
      step('1);
      seen |= gnt;
    end
    vecs++;
    if (seen != '1) fail("R9 full round coverage", seen, '1);

    // table walk: R2, R3, R4, R5, R6 checked on every cycle
    for (int v = 0; v < NV; v++)
      for (int c = 0; c < int'(VEC[v][7:0]); c++) step(VEC[v][23:8]);

    // R7: idle gap keeps the round's winner excluded
    doReset();
    step(16'h0007);
    w = gnt;
    repeat (3) step('0);
    step(16'h0007);
    vecs++;
    if ((gnt & w) != '0) fail("R7 winner re-granted after idle", gnt, 16'h0007 & ~w);

    // R6: two requesters alternate, then the round restarts
    doReset();
    step(16'h0006);
    w = gnt;
    step(16'h0006);
    w2 = gnt;
    vecs++;
    if ((w | w2) != 16'h0006) fail("R6 both requesters served", w | w2, 16'h0006);
    step(16'h0006);
    vecs++;
    if (gnt == '0) fail("R6 restart grant", gnt, 16'h0006);

    // R8: first winners of successive rounds differ at least once
    doReset();
    firstSeen = '0;
    for (int rnd = 0; rnd < 8; rnd++)
      for (int c = 0; c < 16; c++) begin
        step('1);
        if (c == 0) begin
          first = gnt;
          firstSeen |= first;
        end
      end
    vecs++;
    if (ones(firstSeen) < 2) fail("R8 draw varies across rounds", firstSeen, '1);

    step('0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule